// File: doc/BRIEF.md
# Strided Interleaved Vector Memory Controller

This block executes one vector memory command at a time. A command carries a base word address, a constant stride and an element count; the block walks the element addresses in ascending element order and sends each one to one of several word-interleaved banks. Banks need a rest period after each access and answer reads after a fixed latency, so the rate at which elements leave the block depends on how the stride spreads the addresses over the banks. A stride that shares no factor with the bank count keeps one element per cycle. A stride that folds onto a few banks waits on them.

Store commands take their element data from a valid/ready stream, one word per element. Load commands return their element data on a valid/ready stream, always in ascending element order, and tolerate backpressure. A single-cycle completion pulse ends each command, after which the next command is accepted. The bank storage is held inside the block.

Top module: `strided_vmem_ctrl`

## Requirements
- R1: Element i of a command addresses word (base + i * stride) modulo the total word count (256 by default), so any stride value is legal, including 0 and strides that wrap.
- R2: The bank of a word is its address modulo the bank count (the low 4 address bits with the default 16 banks) and the row inside the bank is the remaining upper bits.
- R3: An access may start at a bank no earlier than BUSY (default 4) clock edges after the previous access to that bank started.
- R4: Load data for an element whose access starts at clock edge t is presented on the read stream after edge t + LAT (default 12) when the read stream is not held back.
- R5: Elements start their accesses strictly in element order, one at most per edge; the first may start at the edge after the command is accepted, and each later one starts at the first edge after its predecessor's at which its bank has rested; a stride coprime with the bank count therefore starts one element per edge.
- R6: A unit-stride command with the bank count not below BUSY starts every element on consecutive edges, so a load's data beats arrive without gaps after the initial latency.
- R7: The element count is taken from the 7-bit length field and limited to 64; a length above 64 moves exactly 64 elements, and a length of 0 moves nothing and still completes.
- R8: Load data leaves in ascending element order; while the read stream is stalled, the presented data stays unchanged.
- R9: A store consumes one store-stream word per element, and an element waits while no store word is offered; the word written is the one offered at that element's start edge.
- R10: The completion pulse is high for exactly one cycle: after the edge that accepts the final load beat, or after the edge that starts the final store access, or after the first active edge for a length of 0.
- R11: While a command is in progress, the command port reports not ready and an offered command has no effect.
- R12: Under reset the block reports command-ready, no read data, no store-ready and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and accepting a command |
| cmd_store | input | 1 | 1 for a store command, 0 for a load |
| cmd_base | input | 8 | Word address of element 0 |
| cmd_stride | input | 8 | Word distance between elements, modulo the address space |
| cmd_vlen | input | 7 | Requested element count |
| st_valid | input | 1 | Store word offered |
| st_ready | output | 1 | Current store element can start now |
| st_data | input | 64 | Store word for the current element |
| rd_valid | output | 1 | Load word available |
| rd_ready | input | 1 | Consumer takes the load word |
| rd_data | output | 64 | Load word, ascending element order |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The bench predicts the exact start edge of every element from the bank-rest rule and checks each store handshake and each load beat against it, so a design that checked the wrong bank bits, rested a bank one cycle too long or too short, or added a pipeline stage would show a shifted beat on unit, coprime, bank-folding (8, 16) and zero strides. Lengths of 0, 1, 64 and above 64 probe the limit and the empty command, where an off-by-one counter would move a wrong number of elements or miss the pulse. Random read backpressure and gaps in the store stream target reordering or lost words, and a command offered mid-transfer catches a design that lets it through.

// File: rtl/svmc_pkg.sv
// Package: shared helpers for the strided vector memory controller.
// Assumes callers pass unsigned element counts.
package svmc_pkg;

    // Limit a requested element count to the vector length ceiling.
    function automatic int unsigned clamp_len(int unsigned req, int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/svmc_bank_timer.sv
// Bank rest timer: one down-counter per bank, loaded when an access starts
// at that bank. The selected bank is free once its counter is back at zero.
// Assumes at most one access starts per cycle and BUSY >= 1.
module svmc_bank_timer #(
    parameter int unsigned NBANK = 16,
    parameter int unsigned BUSY  = 4,
    localparam int unsigned BW   = $clog2(NBANK),
    localparam int unsigned CW   = $clog2(BUSY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] sel,
    input  logic          fire,
    output logic          free
);

    localparam logic [CW-1:0] RELOAD = CW'(BUSY - 1);

    logic [CW-1:0] cnt [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Reload on an access to this bank, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[b] <= '0;
            else if (fire && sel == BW'(b))
                cnt[b] <= RELOAD;
            else if (cnt[b] != '0)
                cnt[b] <= cnt[b] - CW'(1);
        end
    end

    assign free = (cnt[sel] == '0);

    if (BUSY > 1) begin : g_chk
        AST_BANK_REVISIT: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> !(fire && sel == $past(sel))); // R3
    end

endmodule

// File: rtl/svmc_bank_store.sv
// Interleaved bank storage with a fixed read latency. One access per cycle,
// to the bank and row given; reads enter a LAT-stage delay line so the word
// appears at ret_* LAT-1 edges after the access edge (registered downstream).
// Assumes LAT >= 2; memory contents are not reset.
module svmc_bank_store #(
    parameter int unsigned NBANK = 16,
    parameter int unsigned ROWS  = 16,
    parameter int unsigned DW    = 64,
    parameter int unsigned LAT   = 12,
    localparam int unsigned BW   = $clog2(NBANK),
    localparam int unsigned RW   = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          we,
    input  logic [BW-1:0] bank,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic          ret_valid,
    output logic [DW-1:0] ret_data
);

    logic [DW-1:0] lane_rd [NBANK];
    logic [DW-1:0] rd_word;
    logic [DW-1:0] pd [LAT];
    logic [LAT-1:0] pv;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem [ROWS];
        // Write the addressed row of this bank on a store access.
        always_ff @(posedge clk) begin
            if (go && we && bank == BW'(b))
                mem[row] <= wdata;
        end
        assign lane_rd[b] = mem[row];
    end

    // Pick the word of the addressed bank.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NBANK; b++)
            if (bank == BW'(b))
                rd_word = lane_rd[b];
    end

    // Valid bits of the latency line, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pv <= '0;
        else
            pv <= {pv[LAT-2:0], go && !we};
    end

    // Data of the latency line, shifted every cycle.
    always_ff @(posedge clk) begin
        pd[0] <= rd_word;
        for (int i = 1; i < LAT; i++)
            pd[i] <= pd[i-1];
    end

    assign ret_valid = pv[LAT-1];
    assign ret_data  = pd[LAT-1];

endmodule

// File: rtl/svmc_ret_fifo.sv
// Return buffer: holds load words between the latency line and the read
// stream. Assumes DEPTH is a power of two and the producer never pushes
// when full (guaranteed by the issue credit in the top).
module svmc_ret_fifo #(
    parameter int unsigned DW    = 64,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW:0]   wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
    assign dout  = mem[rp[PW-1:0]];

    // Store an incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push)
            mem[wp[PW-1:0]] <= din;
    end

    // Advance the pointers on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push)
                wp <= wp + (PW+1)'(1);
            if (pop && !empty)
                rp <= rp + (PW+1)'(1);
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8

endmodule

// File: rtl/strided_vmem_ctrl.sv
// Strided interleaved vector memory controller (top). Accepts one load or
// store command, walks base + i*stride in element order, starts each element
// at its bank once the bank has rested, and returns load data in order.
// Assumes NBANK and ROWS are powers of two and LAT + 2 <= FDEPTH for full
// rate; addresses wrap modulo NBANK*ROWS.
module strided_vmem_ctrl
    import svmc_pkg::*;
#(
    parameter int unsigned NBANK  = 16,
    parameter int unsigned ROWS   = 16,
    parameter int unsigned DW     = 64,
    parameter int unsigned BUSY   = 4,
    parameter int unsigned LAT    = 12,
    parameter int unsigned VLMAX  = 64,
    parameter int unsigned FDEPTH = 16,
    localparam int unsigned BW    = $clog2(NBANK),
    localparam int unsigned RW    = $clog2(ROWS),
    localparam int unsigned AW    = BW + RW,
    localparam int unsigned LW    = $clog2(VLMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_store,
    input  logic [AW-1:0] cmd_base,
    input  logic [AW-1:0] cmd_stride,
    input  logic [LW-1:0] cmd_vlen,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [DW-1:0] st_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    localparam logic [LW-1:0] CREDIT = LW'(FDEPTH);

    logic          active, is_store;
    logic [AW-1:0] cur_addr, stride_r;
    logic [LW-1:0] len_r, iss_cnt, pop_cnt, outstanding;
    logic          accept, bank_free, want, can_go, fire, pop, finish;
    logic          ret_valid, fifo_empty, fifo_full;
    logic [DW-1:0] ret_data;
    logic [BW-1:0] bank_sel;
    logic [RW-1:0] row_sel;

    assign cmd_ready   = !active;
    assign accept      = cmd_valid && cmd_ready;
    assign bank_sel    = cur_addr[BW-1:0];
    assign row_sel     = cur_addr[AW-1:BW];
    assign outstanding = iss_cnt - pop_cnt;
    assign rd_valid    = !fifo_empty;
    assign pop         = rd_valid && rd_ready;

    // Decide whether the current element starts this cycle.
    always_comb begin
        want     = active && (iss_cnt < len_r) && (is_store || outstanding < CREDIT);
        can_go   = want && bank_free;
        st_ready = can_go && is_store;
        fire     = can_go && (!is_store || st_valid);
    end

    // Detect the event that completes the command.
    always_comb begin
        if (len_r == '0)
            finish = active;
        else if (is_store)
            finish = active && fire && (iss_cnt == len_r - LW'(1));
        else
            finish = active && pop && (pop_cnt == len_r - LW'(1));
    end

    // Command state, address walk and element counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            is_store <= 1'b0;
            cur_addr <= '0;
            stride_r <= '0;
            len_r    <= '0;
            iss_cnt  <= '0;
            pop_cnt  <= '0;
            done     <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                active   <= 1'b1;
                is_store <= cmd_store;
                cur_addr <= cmd_base;
                stride_r <= cmd_stride;
                len_r    <= LW'(clamp_len(32'(cmd_vlen), VLMAX));
                iss_cnt  <= '0;
                pop_cnt  <= '0;
            end else if (active) begin
                if (fire) begin
                    cur_addr <= cur_addr + stride_r;
                    iss_cnt  <= iss_cnt + LW'(1);
                end
                if (pop)
                    pop_cnt <= pop_cnt + LW'(1);
                if (finish)
                    active <= 1'b0;
            end
        end
    end

    svmc_bank_timer #(.NBANK(NBANK), .BUSY(BUSY)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (bank_sel),
        .fire (fire),
        .free (bank_free)
    );

    svmc_bank_store #(.NBANK(NBANK), .ROWS(ROWS), .DW(DW), .LAT(LAT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fire),
        .we       (is_store),
        .bank     (bank_sel),
        .row      (row_sel),
        .wdata    (st_data),
        .ret_valid(ret_valid),
        .ret_data (ret_data)
    );

    svmc_ret_fifo #(.DW(DW), .DEPTH(FDEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (ret_valid),
        .din  (ret_data),
        .pop  (pop),
        .dout (rd_data),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R8
    AST_POP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> pop_cnt < iss_cnt); // R8
    AST_NO_RETURN_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        active && is_store |-> !ret_valid && fifo_empty); // R9
    AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        active && !finish |=> !cmd_ready); // R11

endmodule

// File: tb/tb_strided_vmem_ctrl.sv
// Bench: directed corner cases plus seeded random commands, checked against
// a bench-side shadow memory and a bank-rest timing model.
module tb_strided_vmem_ctrl;

    localparam int NB = 16, TOT = 256, BUSY = 4, LAT = 12;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_store = 1'b0;
    logic [7:0]  cmd_base = '0, cmd_stride = '0;
    logic [6:0]  cmd_vlen = '0;
    logic        st_valid = 1'b0, rd_ready = 1'b0;
    logic [63:0] st_data = '0;
    logic        cmd_ready, st_ready, rd_valid, done;
    logic [63:0] rd_data;

    int total = 0, bad = 0;
    logic [63:0] shadow [TOT];
    int exp_t [64];
    int last_k;

    always #2 clk = ~clk;

    strided_vmem_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int v);
        return (v > 64) ? 64 : v;
    endfunction

    function automatic int addr_of(input int base, input int stride, input int i);
        return (base + i * stride) % TOT;
    endfunction

    // Start edges per R3/R5, banks per R2.
    task automatic model(input int base, input int stride, input int len);
        int nf [NB];
        int e;
        for (int b = 0; b < NB; b++) nf[b] = 0;
        e = 1;
        for (int i = 0; i < len; i++) begin
            int bk;
            bk = addr_of(base, stride, i) % NB;
            if (e < nf[bk]) e = nf[bk];
            exp_t[i] = e;
            nf[bk] = e + BUSY;
            e++;
        end
    endtask

    task automatic send_cmd(input bit store, input int base, input int stride, input int vlen);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_store  = store;
        cmd_base   = 8'(base);
        cmd_stride = 8'(stride);
        cmd_vlen   = 7'(vlen);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_cmd(input int k0, input string tag);
        int k;
        k = k0;
        while (k < last_k + 1) begin
            @(posedge clk); @(negedge clk);
            st_valid = 1'b0;
            k++;
        end
        #1;
        check(done === 1'b1, {tag, " R10 done pulse"}, done, 1);
        @(posedge clk); @(negedge clk); #1;
        check(done === 1'b0, {tag, " R10 single cycle"}, done, 0);
        check(cmd_ready === 1'b1, {tag, " R11 ready after done"}, cmd_ready, 1);
    endtask

    task automatic do_store(input int base, input int stride, input int vlen, input bit gaps);
        int len, idx, k;
        len = eff_len(vlen);
        model(base, stride, len);
        send_cmd(1'b1, base, stride, vlen);
        k = 0; idx = 0; last_k = 0;
        while (idx < len && k < 4000) begin
            st_valid = gaps ? 1'($urandom % 2) : 1'b1;
            st_data  = {$urandom, $urandom};
            #1;
            if (st_valid && st_ready) begin
                if (!gaps)
                    check(k + 1 == exp_t[idx], "R3 R5 store start edge", k + 1, exp_t[idx]);
                shadow[addr_of(base, stride, idx)] = st_data;
                idx++;
                last_k = k;
            end
            if (idx < len) begin
                @(posedge clk); @(negedge clk);
                k++;
            end
        end
        check(idx == len, "R9 store count", idx, len);
        finish_cmd(k, "store");
    endtask

    task automatic do_load(input int base, input int stride, input int vlen,
                           input bit bp, input bit inject);
        int len, idx, k;
        len = eff_len(vlen);
        model(base, stride, len);
        send_cmd(1'b0, base, stride, vlen);
        k = 0; idx = 0; last_k = 0;
        while (idx < len && k < 4000) begin
            rd_ready = bp ? 1'($urandom % 2) : 1'b1;
            if (inject && k == 3) begin
                cmd_valid = 1'b1; cmd_store = 1'b1; cmd_base = 8'(base);
            end else
                cmd_valid = 1'b0;
            #1;
            if (inject && k == 3)
                check(cmd_ready === 1'b0, "R11 busy refuses command", cmd_ready, 0);
            if (rd_valid && rd_ready) begin
                check(rd_data === shadow[addr_of(base, stride, idx)], "R1 R8 load data",
                      rd_data, shadow[addr_of(base, stride, idx)]);
                if (!bp)
                    check(k == exp_t[idx] + LAT, "R4 R5 load beat edge", k, exp_t[idx] + LAT);
                idx++;
                last_k = k;
            end
            if (idx < len) begin
                @(posedge clk); @(negedge clk);
                k++;
            end
        end
        cmd_valid = 1'b0;
        rd_ready = 1'b1;
        check(idx == len, "R7 load count", idx, len);
        finish_cmd(k, "load");
    endtask

    initial begin
        #600000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7177));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(cmd_ready === 1'b1, "R12 reset cmd_ready", cmd_ready, 1);
        check(rd_valid === 1'b0, "R12 reset rd_valid", rd_valid, 0);
        check(st_ready === 1'b0, "R12 reset st_ready", st_ready, 0);
        check(done === 1'b0, "R12 reset done", done, 0);
        rst_n = 1'b1;
        rd_ready = 1'b1;

        // Fill memory with unit-stride stores (R6 start edges via model).
        for (int q = 0; q < 4; q++) begin
            do_store(q * 64, 1, 64, 1'b0);
            check(last_k + 1 == 64, "R6 unit-stride store no gaps", last_k + 1, 64);
        end

        // R6: unit-stride load, gap-free beats.
        do_load(5, 1, 64, 1'b0, 1'b0);
        check(last_k == LAT + 64, "R6 unit-stride load end", last_k, LAT + 64);
        // R5: coprime stride keeps full rate.
        do_load(7, 3, 40, 1'b0, 1'b0);
        check(last_k == LAT + 40, "R5 coprime stride rate", last_k, LAT + 40);
        // R3/R2: stride 16 hits a single bank every time.
        do_load(2, 16, 8, 1'b0, 1'b0);
        check(last_k == LAT + 1 + 7 * BUSY, "R3 single-bank stride", last_k, LAT + 1 + 7 * BUSY);
        // R2: stride 8 alternates two banks.
        do_load(0, 8, 10, 1'b0, 1'b0);
        // R1: stride 255 walks downwards with wrap; stride 0 repeats one word.
        do_load(3, 255, 20, 1'b0, 1'b0);
        do_load(200, 0, 5, 1'b0, 1'b0);
        // R7: length limits.
        do_load(17, 5, 100, 1'b0, 1'b0);
        do_load(9, 1, 1, 1'b0, 1'b0);
        do_load(9, 1, 0, 1'b0, 1'b0);
        do_store(9, 1, 0, 1'b0);
        // R9: store with gaps in the store stream, then read back.
        do_store(30, 7, 33, 1'b1);
        do_load(30, 7, 33, 1'b0, 1'b0);
        // R8: backpressure; R11: command offered mid-transfer.
        do_load(11, 1, 64, 1'b1, 1'b0);
        do_load(40, 3, 30, 1'b0, 1'b1);
        do_load(40, 3, 30, 1'b1, 1'b0);

        // Seeded random commands.
        for (int n = 0; n < 40; n++) begin
            int op, b, s, v;
            op = $urandom % 3;
            b  = $urandom % TOT;
            s  = $urandom % TOT;
            v  = $urandom % 72;
            if (op == 0)      do_store(b, s, v, 1'($urandom % 2));
            else if (op == 1) do_load(b, s, v, 1'b0, 1'b0);
            else              do_load(b, s, v, 1'b1, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule